// File: doc/BRIEF.md
# Bit-Oriented Message Transceiver

This block carries short coded messages over a slow serial overhead link whose bits advance on a single-cycle strobe from the system clock domain. On the send side it loops a sixteen-bit frame with no gaps. Each frame is a run of eight ones, a zero, a six-bit code taken from a software-written setting, and a closing zero. A new setting is picked up only at a frame boundary.

On the receive side the block first searches the incoming bits for eight ones followed by a zero, and then tracks frame positions. For each frame it forms a candidate code. A candidate is accepted only when it matches at least seven of the ten most recent candidates, counting itself. Once accepted, the code is latched into a readable output. If the latched code is new, a sticky pending flag is set. The interrupt line shows that flag unless the mask input hides it. A single-cycle acknowledge clears the flag.

Both serial directions are paced only by the bit strobe. Neither can stall, so the link carries no valid/ready handshake and has no back-pressure: one bit is presented and one bit is consumed on every strobe while the link is enabled. The code setting, the mask, the acknowledge and the received code are plain level or pulse signals.

Top module: `biom_xcvr`

## Requirements
- R1: While enabled, the transmit bit follows a repeating sixteen-bit frame, advancing one position per strobe: positions 0–7 are 1, position 8 is 0, positions 9–14 carry the code MSB first (tx_code[5] at position 9), and position 15 is 0. The first strobe after enabling sends position 0.
- R2: A change to tx_code in the middle of a frame leaves the rest of that frame unchanged. The new code appears from the next frame onward.
- R3: While link_en is low, tx_bit is 1 and rx_msg, irq and the pending flag do not change. On enabling, the transmitter restarts at position 0, and the receiver restarts its search with an empty history.
- R4: The receiver locks after it sees eight consecutive 1 bits followed by a 0, and treats that 0 as position 8 of a frame. While locked, a 0 at any of positions 0–7 drops the lock and empties the candidate history.
- R5: A candidate is accepted when at least 7 of the last 10 candidates, including the current one, are well-formed and carry the same code. rx_msg then takes that code on the clock edge of the strobe that received position 15.
- R6: A candidate whose position-8 bit or position-15 bit is 1 is stored as a non-matching entry and is never accepted. The lock is kept.
- R7: Accepting a code that differs from the code held in rx_msg, or accepting the first code after reset, sets a sticky pending flag. irq equals pending AND irq_en, so a masked event becomes visible once irq_en rises.
- R8: A pulse on irq_ack clears the pending flag, and a new acceptance in the same cycle takes priority over the pulse. Accepting the code already held again does not set the flag.
- R9: Without a strobe on dl_tick, neither tx_bit nor the receive state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dl_tick | input | 1 | One-cycle strobe marking each link bit time |
| link_en | input | 1 | Enables message transfer in both directions |
| tx_code | input | 6 | Code to be sent in each frame |
| rx_bit | input | 1 | Serial receive bit, sampled on dl_tick |
| irq_en | input | 1 | Interrupt enable (1 lets the pending flag through) |
| irq_ack | input | 1 | One-cycle pulse that clears the pending flag |
| tx_bit | output | 1 | Serial transmit bit for the current strobe |
| rx_msg | output | 6 | Last accepted code |
| irq | output | 1 | Interrupt, high while pending and enabled |

## Verification
Several rules are checked by the assertions on every clock cycle. rx_msg holds while the link is off or no strobe arrives. tx_bit is steady between strobes. Any change of rx_msg comes with the pending flag set. An acknowledge with no acceptance in the same cycle clears the interrupt. Accepting the code already held leaves the flag down. Only the directed scenarios can show the exact frame layout and the boundary at which a new code takes effect. They also cover the seven-of-ten threshold in a sliding window where the sixth match fails and the seventh passes, the handling of malformed candidates, the emptying of the history after a lost lock, and an end-to-end loop from the transmitter back into the receiver.

// File: rtl/biom_pkg.sv
package biom_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } align_state_e;
endpackage

// File: rtl/biom_tx.sv
module biom_tx #(
  parameter int CODE_W  = 6,
  parameter int PRE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dl_tick,
  input  logic              link_en,
  input  logic [CODE_W-1:0] tx_code,
  output logic              tx_bit
);
  localparam int FRAME_LEN = PRE_LEN + CODE_W + 2;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0]  pos;
  logic [CODE_W-1:0] shadow;

  // shadow copy only reloads at a frame boundary or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      shadow <= '0;
    end else if (!link_en) begin
      pos    <= '0;
      shadow <= tx_code;
    end else if (dl_tick) begin
      if (pos == LAST_POS) begin
        pos    <= '0;
        shadow <= tx_code;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  always_comb begin
    tx_bit = 1'b1;
    if (link_en) begin
      if (int'(pos) == PRE_LEN || pos == LAST_POS) tx_bit = 1'b0;
      for (int k = 0; k < CODE_W; k++) begin
        if (int'(pos) == PRE_LEN + 1 + k) tx_bit = shadow[CODE_W-1-k];
      end
    end
  end
endmodule

// File: rtl/biom_rx_align.sv
module biom_rx_align
  import biom_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int PRE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dl_tick,
  input  logic              link_en,
  input  logic              rx_bit,
  output logic              cand_stb,
  output logic              cand_ok,
  output logic [CODE_W-1:0] cand_code,
  output logic              lost
);
  localparam int FRAME_LEN = PRE_LEN + CODE_W + 2;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int RUN_W     = $clog2(PRE_LEN + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(PRE_LEN);

  align_state_e      state;
  logic [POS_W-1:0]  pos;
  logic [RUN_W-1:0]  run;
  logic              lead_bad;
  logic [CODE_W-1:0] code_sr;
  logic              step;

  assign step      = dl_tick && link_en;
  assign lost      = step && (state == ST_LOCKED) && (int'(pos) < PRE_LEN) && !rx_bit;
  assign cand_stb  = step && (state == ST_LOCKED) && (pos == LAST_POS);
  assign cand_ok   = !lead_bad && !rx_bit;
  assign cand_code = code_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      pos      <= '0;
      run      <= '0;
      lead_bad <= 1'b0;
      code_sr  <= '0;
    end else if (!link_en) begin
      state    <= ST_HUNT;
      pos      <= '0;
      run      <= '0;
      lead_bad <= 1'b0;
    end else if (dl_tick) begin
      unique case (state)
        ST_HUNT: begin
          if (run == RUN_FULL && !rx_bit) begin
            state    <= ST_LOCKED;
            pos      <= POS_W'(PRE_LEN + 1);
            lead_bad <= 1'b0;
            run      <= '0;
          end else if (rx_bit) begin
            if (run != RUN_FULL) run <= run + RUN_W'(1);
          end else begin
            run <= '0;
          end
        end
        ST_LOCKED: begin
          if (lost) begin
            state <= ST_HUNT;
            pos   <= '0;
            run   <= '0;
          end else begin
            if (int'(pos) == PRE_LEN) lead_bad <= rx_bit;
            if (int'(pos) > PRE_LEN && pos != LAST_POS)
              code_sr <= {code_sr[CODE_W-2:0], rx_bit};
            pos <= (pos == LAST_POS) ? '0 : pos + POS_W'(1);
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/biom_persist.sv
module biom_persist #(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 10,
  parameter int THRESH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cand_stb,
  input  logic              cand_ok,
  input  logic [CODE_W-1:0] cand_code,
  output logic              acc_stb,
  output logic [CODE_W-1:0] acc_code
);
  localparam int HIST  = DEPTH - 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [HIST-1:0]   hist_vld;
  logic [CODE_W-1:0] hist_code [HIST];
  logic [HIST-1:0]   hit_vec;
  logic [CNT_W-1:0]  hits;

  for (genvar g = 0; g < HIST; g++) begin : g_cmp
    assign hit_vec[g] = hist_vld[g] && (hist_code[g] == cand_code);
  end

  always_comb begin
    hits = CNT_W'(cand_ok);
    for (int k = 0; k < HIST; k++) hits = hits + CNT_W'(hit_vec[k]);
  end

  assign acc_stb  = cand_stb && cand_ok && (hits >= CNT_W'(THRESH));
  assign acc_code = cand_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_vld <= '0;
      for (int k = 0; k < HIST; k++) hist_code[k] <= '0;
    end else if (flush) begin
      hist_vld <= '0;
    end else if (cand_stb) begin
      hist_vld     <= {hist_vld[HIST-2:0], cand_ok};
      hist_code[0] <= cand_code;
      for (int k = 1; k < HIST; k++) hist_code[k] <= hist_code[k-1];
    end
  end
endmodule

// File: rtl/biom_xcvr.sv
module biom_xcvr #(
  parameter int CODE_W  = 6,
  parameter int PRE_LEN = 8,
  parameter int DEPTH   = 10,
  parameter int THRESH  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dl_tick,
  input  logic              link_en,
  input  logic [CODE_W-1:0] tx_code,
  input  logic              rx_bit,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic              tx_bit,
  output logic [CODE_W-1:0] rx_msg,
  output logic              irq
);
  logic              cand_stb, cand_ok, lost;
  logic [CODE_W-1:0] cand_code;
  logic              acc_stb, acc_new;
  logic [CODE_W-1:0] acc_code;
  logic              have_msg, pend;

  biom_tx #(.CODE_W(CODE_W), .PRE_LEN(PRE_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .dl_tick(dl_tick), .link_en(link_en),
    .tx_code(tx_code), .tx_bit(tx_bit)
  );

  biom_rx_align #(.CODE_W(CODE_W), .PRE_LEN(PRE_LEN)) u_align (
    .clk(clk), .rst_n(rst_n), .dl_tick(dl_tick), .link_en(link_en),
    .rx_bit(rx_bit), .cand_stb(cand_stb), .cand_ok(cand_ok),
    .cand_code(cand_code), .lost(lost)
  );

  biom_persist #(.CODE_W(CODE_W), .DEPTH(DEPTH), .THRESH(THRESH)) u_persist (
    .clk(clk), .rst_n(rst_n), .flush(lost || !link_en),
    .cand_stb(cand_stb), .cand_ok(cand_ok), .cand_code(cand_code),
    .acc_stb(acc_stb), .acc_code(acc_code)
  );

  assign acc_new = acc_stb && (!have_msg || (acc_code != rx_msg));
  assign irq     = pend && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_msg   <= '0;
      have_msg <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (acc_stb) begin
        rx_msg   <= acc_code;
        have_msg <= 1'b1;
      end
      if (acc_new)      pend <= 1'b1;
      else if (irq_ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/biom_xcvr_chk.sv
module biom_xcvr_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dl_tick,
  input logic              link_en,
  input logic              irq_ack,
  input logic              tx_bit,
  input logic [CODE_W-1:0] rx_msg,
  input logic              irq,
  input logic              pend,
  input logic              acc_stb,
  input logic              acc_new
);
  // R3
  off_holds_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> $stable(rx_msg));

  // R9
  tick_gates_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dl_tick && link_en) |=> (!link_en || $stable(tx_bit)));

  // R9
  tick_gates_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_tick |=> $stable(rx_msg));

  // R7
  change_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_msg) |-> pend);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !acc_stb) |=> !irq);

  // R8
  same_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_new && !pend) |=> !pend);
endmodule

bind biom_xcvr biom_xcvr_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dl_tick(dl_tick), .link_en(link_en),
  .irq_ack(irq_ack), .tx_bit(tx_bit), .rx_msg(rx_msg), .irq(irq),
  .pend(pend), .acc_stb(acc_stb), .acc_new(acc_new)
);

// File: tb/biom_xcvr_bench.sv
module biom_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dl_tick = 1'b0;
  logic       link_en = 1'b0;
  logic [5:0] tx_code = '0;
  logic       rx_bit = 1'b1;
  logic       irq_en = 1'b1;
  logic       irq_ack = 1'b0;
  logic       tx_bit;
  logic [5:0] rx_msg;
  logic       irq;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   loop_mode = 1'b0;
  logic [15:0] tx_cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  biom_xcvr u_biom_xcvr (
    .clk(clk), .rst_n(rst_n), .dl_tick(dl_tick), .link_en(link_en),
    .tx_code(tx_code), .rx_bit(rx_bit), .irq_en(irq_en), .irq_ack(irq_ack),
    .tx_bit(tx_bit), .rx_msg(rx_msg), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] frame(input logic [5:0] c, input logic ld, input logic tr);
    return {8'hFF, ld, c, tr};
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit  = loop_mode ? tx_bit : b;
    tx_cap  = {tx_cap[14:0], tx_bit};
    dl_tick = 1'b1;
    @(negedge clk);
    dl_tick = 1'b0;
    repeat (TICK_GAP) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_frames(input logic [5:0] c, input int n);
    for (int i = 0; i < n; i++) send_word(frame(c, 1'b0, 1'b0));
  endtask

  task automatic ack_pulse;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic restart_link;
    @(negedge clk); link_en = 1'b0;
    @(negedge clk); link_en = 1'b1;
  endtask

  task automatic t_reset;
    chk("R3 tx idle after reset", tx_bit, 1);
    chk("R3 rx_msg after reset", rx_msg, 0);
    chk("R7 irq after reset", irq, 0);
  endtask

  task automatic t_tx_frames;
    logic [5:0] c0, c1;
    c0 = 6'b101101; c1 = 6'b010010;
    tx_code = c0;
    restart_link();
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    repeat (10) @(negedge clk);
    chk("R9 tx holds position 8 without strobe", tx_bit, 0);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    chk("R1 first frame", tx_cap, frame(c0, 1'b0, 1'b0));
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    chk("R1 second frame", tx_cap, frame(c0, 1'b0, 1'b0));
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    tx_code = c1;
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    chk("R2 frame in flight keeps old code", tx_cap, frame(c0, 1'b0, 1'b0));
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    chk("R2 next frame carries new code", tx_cap, frame(c1, 1'b0, 1'b0));
  endtask

  task automatic t_accept;
    logic [5:0] a;
    a = 6'b110101;
    restart_link();
    send_frames(a, 6);
    chk("R5 six matches not accepted", rx_msg, 0);
    chk("R7 no irq before accept", irq, 0);
    send_frames(a, 1);
    chk("R4 R5 seventh match accepted", rx_msg, a);
    chk("R7 irq on first accept", irq, 1);
  endtask

  task automatic t_ack;
    ack_pulse();
    chk("R8 ack clears irq", irq, 0);
    send_frames(6'b110101, 3);
    chk("R8 requalify same code no irq", irq, 0);
    chk("R8 rx_msg unchanged", rx_msg, 6'b110101);
  endtask

  task automatic t_mask;
    logic [5:0] b;
    b = 6'b001110;
    irq_en = 1'b0;
    send_frames(b, 6);
    chk("R5 six of new code not accepted", rx_msg, 6'b110101);
    send_frames(b, 1);
    chk("R5 new code accepted", rx_msg, b);
    chk("R7 masked irq low", irq, 0);
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    chk("R7 pending shows after unmask", irq, 1);
    ack_pulse();
    chk("R8 ack after unmask", irq, 0);
  endtask

  task automatic t_window;
    logic [5:0] c, d;
    c = 6'b011011; d = 6'b100100;
    for (int i = 0; i < 5; i++) begin
      send_frames(c, 1);
      send_frames(d, 1);
    end
    chk("R5 alternating codes rejected", rx_msg, 6'b001110);
    send_frames(c, 3);
    chk("R5 window holds six of code", rx_msg, 6'b001110);
    send_frames(c, 1);
    chk("R5 window reaches seven", rx_msg, c);
    chk("R7 irq for new code", irq, 1);
    ack_pulse();
  endtask

  task automatic t_framing;
    logic [5:0] e;
    e = 6'b000111;
    for (int i = 0; i < 5; i++) send_word(frame(e, 1'b0, 1'b1));
    for (int i = 0; i < 5; i++) send_word(frame(e, 1'b1, 1'b0));
    chk("R6 malformed candidates rejected", rx_msg, 6'b011011);
    chk("R6 no irq", irq, 0);
    send_frames(e, 6);
    chk("R6 malformed entries do not count", rx_msg, 6'b011011);
    send_frames(e, 1);
    chk("R6 lock kept, seven good accepted", rx_msg, e);
    ack_pulse();
  endtask

  task automatic t_loss;
    logic [5:0] f;
    f = 6'b101011;
    send_frames(f, 6);
    send_word({8'b11101111, 1'b0, f, 1'b0});
    chk("R4 corrupt preamble frame not counted", rx_msg, 6'b000111);
    send_frames(f, 6);
    chk("R4 history emptied on lost lock", rx_msg, 6'b000111);
    send_frames(f, 1);
    chk("R4 relock and accept", rx_msg, f);
    ack_pulse();
  endtask

  task automatic t_disable;
    @(negedge clk); link_en = 1'b0;
    send_frames(6'b111000, 8);
    chk("R3 tx all ones while off", tx_cap, 16'hFFFF);
    chk("R3 rx_msg held while off", rx_msg, 6'b101011);
    chk("R3 no irq while off", irq, 0);
  endtask

  task automatic t_loop;
    logic [5:0] g;
    g = 6'b111000;
    tx_code = g;
    loop_mode = 1'b1;
    restart_link();
    send_frames(g, 6);
    chk("R5 loop six frames", rx_msg, 6'b101011);
    send_frames(g, 1);
    chk("R1 R5 loopback accepted", rx_msg, g);
    chk("R7 loopback irq", irq, 1);
    loop_mode = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_frames();
    t_accept();
    t_ack();
    t_mask();
    t_window();
    t_framing();
    t_loss();
    t_disable();
    t_loop();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule